// File: doc/BRIEF.md
# Video Timing Lock Detector

This block watches a parallel video input on its pixel clock. It counts how many qualified pixels each line carries and how many such lines fall between two frame boundaries. When the same geometry has been measured on three complete frames in a row, it raises a `locked` flag. That flag is meant to be wired to the enable of a downstream stream converter, so that the converter forwards nothing while the input is missing, unstable or still settling.

A parameter selects which timing signals qualify the data-valid strobe. The choices are sync pulses only, blanking only, or both. The lock drops at once on any disagreement: a line of the wrong length while locked, a frame whose geometry differs from the stored one, or a frame boundary that does not arrive in time. The last geometry that was accepted, and the lock bit, can be read through a registered status-read port in the style of a memory-mapped register file.

Top module: `videoLockDetect`

## Requirements
- R1: A pixel counts as active only when `dataValid` is high and the blanking or sync inputs selected by `TIMING_SET` are low. With 0 (sync only) these are `hsyncIn` and `vsyncIn`. With 1 (blank only) they are `hblankIn` and `vblankIn`. With 2 (both, the default) all four apply. A frame boundary is the rising edge of `vsyncIn` in modes 0 and 2, and the rising edge of `vblankIn` in mode 1. A `dataValid` pulse inside a sync or blanking interval changes neither the measurements nor the lock.
- R2: The pixel count of a line is the length of one unbroken run of active pixels. The accepted value reads at address 0 in bits [CNT_W-1:0], and the upper bits are zero.
- R3: The line count of a frame is the number of active runs between two successive frame boundaries. The accepted value reads at address 1 in bits [CNT_W-1:0].
- R4: Measurements are stored only at a boundary that closes a complete frame. The frame must hold at least one line, and all of its lines must have equal length. The first boundary after reset or after a watchdog expiry only opens a frame. A frame with unequal lines leaves the stored values untouched.
- R5: `locked` rises on the clock edge that detects the boundary closing the LOCK_FRAMES-th (default 3) consecutive accepted frame with identical pixel and line counts.
- R6: A frame that closes with a pixel or line count different from the stored one drops `locked`. The stability count then restarts with that frame as frame one. A frame with unequal lines drops `locked` and resets the count to zero.
- R7: While locked, a line whose length differs from the stored pixel count drops `locked` at the end of that line, without waiting for the frame boundary.
- R8: If no frame boundary arrives within WDOG_LIMIT clocks of the previous one, `locked` drops, the stability count clears, and the next boundary only opens a frame. Stored measurements are kept.
- R9: A read has one clock of latency: `regRdData` shows the word for the `regAddr` sampled on the previous edge. At address 2, bit 8 is the lock state and every other bit (including [7:0]) is zero. Address 3 reads as zero.
- R10: A synchronous reset clears `locked`, the measurements, the counters and the read data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| vsyncIn | input | 1 | Vertical sync pulse |
| hsyncIn | input | 1 | Horizontal sync pulse |
| vblankIn | input | 1 | Vertical blanking interval |
| hblankIn | input | 1 | Horizontal blanking interval |
| dataValid | input | 1 | Pixel data valid strobe |
| regAddr | input | 2 | Status register select |
| regRdData | output | 32 | Registered read data |
| locked | output | 1 | Timing stable; enable for the downstream converter |

## Verification
The bench puts `dataValid` pulses inside sync and vertical blanking. A design that failed to gate them would lose lock or store a longer line. It corrupts the first line of a frame while locked. A design that waits for the boundary would still report lock mid-frame, and one that stores non-uniform frames would read back the corrupted width. It changes the line count alone and the pixel count alone, and checks that relock takes exactly three frames each time. Finally it lets the watchdog expire and then resumes the same geometry. A design that keeps the half-open frame after expiry would relock one frame early.

// File: rtl/videoLockPkg.sv
package videoLockPkg;

  // Which timing inputs qualify data-valid and mark the frame boundary.
  typedef enum logic [1:0] {
    SET_SYNC  = 2'd0,
    SET_BLANK = 2'd1,
    SET_BOTH  = 2'd2
  } timingSet_e;

  // Datapath to control: per-cycle observations.
  typedef struct packed {
    logic lineEnd;        // an active run just ended
    logic frameEdge;      // frame boundary detected this cycle
    logic frameUniform;   // all lines of the closing frame equal
    logic frameHasLines;  // closing frame carried at least one line
    logic sameAsMeas;     // closing frame equals stored geometry
    logic lineMatch;      // ending line equals stored pixel count
  } dpFlags_t;

  // Control to datapath: strobes.
  typedef struct packed {
    logic capture;        // store the closing frame's geometry
    logic restart;        // discard the partial frame (watchdog)
  } ctrlStrobe_t;

  localparam logic [1:0] ADDR_PIX    = 2'd0;
  localparam logic [1:0] ADDR_LINES  = 2'd1;
  localparam logic [1:0] ADDR_STATUS = 2'd2;
  localparam int         STATUS_LOCK_BIT = 8;

endpackage

// File: rtl/videoLockDatapath.sv
module videoLockDatapath
  import videoLockPkg::*;
#(
  parameter timingSet_e TIMING_SET = SET_BOTH,
  parameter int         CNT_W      = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vsyncIn,
  input  logic             hsyncIn,
  input  logic             vblankIn,
  input  logic             hblankIn,
  input  logic             dataValid,
  input  ctrlStrobe_t      ctrl,
  output dpFlags_t         flags,
  output logic [CNT_W-1:0] measPix,
  output logic [CNT_W-1:0] measLines
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic pixGate;
  logic vertSig;

  // Select the qualifying timing set.
  if (TIMING_SET == SET_SYNC) begin : gSync
    assign pixGate = hsyncIn | vsyncIn;
    assign vertSig = vsyncIn;
  end else if (TIMING_SET == SET_BLANK) begin : gBlank
    assign pixGate = hblankIn | vblankIn;
    assign vertSig = vblankIn;
  end else begin : gBoth
    assign pixGate = hsyncIn | vsyncIn | hblankIn | vblankIn;
    assign vertSig = vsyncIn;
  end

  logic             active;
  logic             actQ;
  logic             vertQ;
  logic [CNT_W-1:0] pixRun;
  logic [CNT_W-1:0] lineCnt;
  logic [CNT_W-1:0] refLen;
  logic             uniform;

  logic             lineEnd;
  logic             frameEdge;
  logic [CNT_W-1:0] curLines;
  logic [CNT_W-1:0] curRef;
  logic             lenOk;
  logic             curUniform;

  assign active    = dataValid & ~pixGate;
  assign lineEnd   = actQ & ~active;
  assign frameEdge = vertSig & ~vertQ;

  // Frame totals as they stand including a line ending this cycle.
  always_comb begin
    curLines   = (lineEnd && lineCnt != CNT_MAX) ? lineCnt + 1'b1 : lineCnt;
    curRef     = (lineEnd && lineCnt == '0) ? pixRun : refLen;
    lenOk      = (lineCnt == '0) || (pixRun == refLen);
    curUniform = uniform & (~lineEnd | lenOk);
  end

  always_comb begin
    flags.lineEnd       = lineEnd;
    flags.frameEdge     = frameEdge;
    flags.frameUniform  = curUniform;
    flags.frameHasLines = (curLines != '0);
    flags.sameAsMeas    = (curRef == measPix) && (curLines == measLines);
    flags.lineMatch     = (pixRun == measPix);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      actQ      <= 1'b0;
      vertQ     <= 1'b0;
      pixRun    <= '0;
      lineCnt   <= '0;
      refLen    <= '0;
      uniform   <= 1'b1;
      measPix   <= '0;
      measLines <= '0;
    end else begin
      actQ  <= active;
      vertQ <= vertSig;

      if (active) begin
        if (!actQ)                pixRun <= CNT_ONE;
        else if (pixRun != CNT_MAX) pixRun <= pixRun + 1'b1;
      end

      if (frameEdge || ctrl.restart) begin
        lineCnt <= '0;
        refLen  <= '0;
        uniform <= 1'b1;
      end else if (lineEnd) begin
        lineCnt <= curLines;
        refLen  <= curRef;
        uniform <= curUniform;
      end

      if (ctrl.capture) begin
        measPix   <= curRef;
        measLines <= curLines;
      end
    end
  end

endmodule

// File: rtl/videoLockCtrl.sv
module videoLockCtrl
  import videoLockPkg::*;
#(
  parameter int LOCK_FRAMES = 3,
  parameter int WDOG_LIMIT  = 1 << 22
) (
  input  logic        clk,
  input  logic        rst,
  input  dpFlags_t    flags,
  output ctrlStrobe_t ctrl,
  output logic        locked,
  output logic        wdogHit
);

  localparam int STAB_W = $clog2(LOCK_FRAMES + 1);
  localparam int WD_W   = $clog2(WDOG_LIMIT + 1);
  localparam logic [STAB_W-1:0] STAB_MAX = STAB_W'(LOCK_FRAMES);
  localparam logic [WD_W-1:0]   WD_MAX   = WD_W'(WDOG_LIMIT);

  logic              seenEdge;
  logic [STAB_W-1:0] stabCnt;
  logic [STAB_W-1:0] stabNext;
  logic [WD_W-1:0]   wdogCnt;
  logic              frameValid;

  assign wdogHit    = (wdogCnt == WD_MAX);
  assign frameValid = seenEdge & flags.frameUniform & flags.frameHasLines;

  always_comb begin
    if (flags.sameAsMeas && stabCnt != '0)
      stabNext = (stabCnt == STAB_MAX) ? stabCnt : stabCnt + 1'b1;
    else
      stabNext = STAB_W'(1);
  end

  always_comb begin
    ctrl.capture = flags.frameEdge & frameValid;
    ctrl.restart = wdogHit & ~flags.frameEdge;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seenEdge <= 1'b0;
      stabCnt  <= '0;
      wdogCnt  <= '0;
      locked   <= 1'b0;
    end else if (flags.frameEdge) begin
      wdogCnt  <= '0;
      seenEdge <= 1'b1;
      if (frameValid) begin
        stabCnt <= stabNext;
        locked  <= (stabNext >= STAB_MAX);
      end else begin
        stabCnt <= '0;
        locked  <= 1'b0;
      end
    end else if (wdogHit) begin
      seenEdge <= 1'b0;
      stabCnt  <= '0;
      locked   <= 1'b0;
    end else begin
      wdogCnt <= wdogCnt + 1'b1;
      if (flags.lineEnd && locked && !flags.lineMatch) begin
        locked  <= 1'b0;
        stabCnt <= '0;
      end
    end
  end

endmodule

// File: rtl/videoLockDetect.sv
module videoLockDetect
  import videoLockPkg::*;
#(
  parameter timingSet_e TIMING_SET  = SET_BOTH,
  parameter int         CNT_W       = 12,
  parameter int         LOCK_FRAMES = 3,
  parameter int         WDOG_LIMIT  = 1 << 22
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        vsyncIn,
  input  logic        hsyncIn,
  input  logic        vblankIn,
  input  logic        hblankIn,
  input  logic        dataValid,
  input  logic [1:0]  regAddr,
  output logic [31:0] regRdData,
  output logic        locked
);

  dpFlags_t         flags;
  ctrlStrobe_t      ctrl;
  logic [CNT_W-1:0] measPix;
  logic [CNT_W-1:0] measLines;
  logic             wdogHit;

  videoLockDatapath #(
    .TIMING_SET(TIMING_SET),
    .CNT_W     (CNT_W)
  ) datapath_i (
    .clk      (clk),
    .rst      (rst),
    .vsyncIn  (vsyncIn),
    .hsyncIn  (hsyncIn),
    .vblankIn (vblankIn),
    .hblankIn (hblankIn),
    .dataValid(dataValid),
    .ctrl     (ctrl),
    .flags    (flags),
    .measPix  (measPix),
    .measLines(measLines)
  );

  videoLockCtrl #(
    .LOCK_FRAMES(LOCK_FRAMES),
    .WDOG_LIMIT (WDOG_LIMIT)
  ) ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .flags  (flags),
    .ctrl   (ctrl),
    .locked (locked),
    .wdogHit(wdogHit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      regRdData <= '0;
    end else begin
      case (regAddr)
        ADDR_PIX:    regRdData <= 32'(measPix);
        ADDR_LINES:  regRdData <= 32'(measLines);
        ADDR_STATUS: regRdData <= 32'(locked) << STATUS_LOCK_BIT;
        default:     regRdData <= '0;
      endcase
    end
  end

endmodule

// File: rtl/videoLockChecker.sv
module videoLockChecker #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             locked,
  input logic [1:0]       regAddr,
  input logic [31:0]      regRdData,
  input logic [CNT_W-1:0] measPix,
  input logic [CNT_W-1:0] measLines,
  input logic             frameEdge,
  input logic             lineEnd,
  input logic             wdogHit
);

  logic pastRst;
  always_ff @(posedge clk) pastRst <= rst;

  // R10: one edge after reset, everything is clear.
  always_ff @(posedge clk) begin
    if (pastRst === 1'b1) begin
      assert_reset_clears_R10: assert (!locked && measPix == '0 && measLines == '0 && regRdData == '0)
        else $error("reset did not clear state");
    end
  end

  // R5: lock only with a stored non-empty geometry.
  assert_lock_has_meas_R5: assert property (@(posedge clk) disable iff (rst)
    locked |-> (measPix != '0 && measLines != '0));

  // R5: lock rises only on a frame boundary.
  assert_lock_rise_at_edge_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(locked)) |-> $past(frameEdge));

  // R6/R7/R8: lock falls only at a frame boundary, line end or watchdog expiry.
  assert_lock_fall_cause_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(locked)) |-> $past(frameEdge || lineEnd || wdogHit));

  // R4: stored geometry moves only at a frame boundary.
  assert_meas_only_at_edge_R4: assert property (@(posedge clk) disable iff (rst)
    !frameEdge |=> ($stable(measPix) && $stable(measLines)));

  // R9: status word carries the lock at bit 8 only.
  assert_status_word_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(regAddr) == 2'd2) |-> (regRdData == (32'($past(locked)) << 8)));

  // R9: unused address reads zero.
  assert_unused_addr_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(regAddr) == 2'd3) |-> (regRdData == '0));

endmodule

bind videoLockDetect videoLockChecker #(
  .CNT_W(CNT_W)
) checker_i (
  .clk      (clk),
  .rst      (rst),
  .locked   (locked),
  .regAddr  (regAddr),
  .regRdData(regRdData),
  .measPix  (measPix),
  .measLines(measLines),
  .frameEdge(flags.frameEdge),
  .lineEnd  (flags.lineEnd),
  .wdogHit  (wdogHit)
);

// File: tb/videoLockDetect_tb_top.sv
module videoLockDetect_tb_top;
  import videoLockPkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG       = 400;

  logic        clk = 1'b0;
  logic        rst;
  logic        vsyncIn, hsyncIn, vblankIn, hblankIn, dataValid;
  logic [1:0]  regAddr;
  logic [31:0] regRdData;
  logic        locked;

  int checks   = 0;
  int failures = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  videoLockDetect #(
    .TIMING_SET (SET_BOTH),
    .CNT_W      (12),
    .LOCK_FRAMES(3),
    .WDOG_LIMIT (WDOG)
  ) dut_i (
    .clk      (clk),
    .rst      (rst),
    .vsyncIn  (vsyncIn),
    .hsyncIn  (hsyncIn),
    .vblankIn (vblankIn),
    .hblankIn (hblankIn),
    .dataValid(dataValid),
    .regAddr  (regAddr),
    .regRdData(regRdData),
    .locked   (locked)
  );

  typedef struct {
    string tag;
    bit    lock;
    int    pix;
    int    lines;
  } expItem_t;

  expItem_t expQ[$];

  task automatic checkVal(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic pushExp(string tag, bit lock, int pix, int lines);
    expItem_t it;
    it.tag = tag; it.lock = lock; it.pix = pix; it.lines = lines;
    expQ.push_back(it);
  endtask

  // One pixel clock with the given input levels.
  task automatic step(bit vs, bit hs, bit vb, bit hb, bit de);
    @(negedge clk);
    vsyncIn = vs; hsyncIn = hs; vblankIn = vb; hblankIn = hb; dataValid = de;
  endtask

  task automatic idleCycles(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
  endtask

  task automatic driveLine(int len, bit spurious);
    step(0, 1, 0, 1, spurious);
    step(0, 1, 0, 1, spurious);
    step(0, 0, 0, 1, spurious);
    for (int i = 0; i < len; i++) step(0, 0, 0, 0, 1);
    step(0, 0, 0, 1, 0);
  endtask

  // Frame: vertical interval, then lines. Pushes the expected state right
  // after the boundary edge, and after a corrupted line if badIdx >= 0.
  task automatic driveFrame(int pix, int lines, int badIdx, int badLen, bit spurious,
                            string tag, bit expLock, int expPix, int expLines,
                            string midTag);
    step(1, 0, 1, 1, 0);
    step(1, 0, 1, 1, spurious);
    pushExp(tag, expLock, expPix, expLines);
    step(1, 0, 1, 1, spurious);
    for (int i = 0; i < 6; i++) step(0, 0, 1, 1, spurious && (i % 2 == 0));
    for (int ln = 0; ln < lines; ln++) begin
      driveLine((ln == badIdx) ? badLen : pix, spurious);
      if (ln == badIdx) pushExp(midTag, 1'b0, expPix, expLines);
    end
  endtask

  // Monitor: pops expectations and reads the register port.
  initial begin
    expItem_t it;
    logic [31:0] vPix, vLines, vStat, vNone;
    logic lockPort;
    regAddr = 2'd0;
    forever begin
      @(negedge clk);
      if (expQ.size() != 0 && rst == 1'b0) begin
        it = expQ.pop_front();
        regAddr = 2'd0;
        @(negedge clk); vPix = regRdData;   regAddr = 2'd1;
        @(negedge clk); vLines = regRdData; regAddr = 2'd2;
        @(negedge clk); vStat = regRdData;  lockPort = locked; regAddr = 2'd3;
        @(negedge clk); vNone = regRdData;  regAddr = 2'd0;
        checkVal(it.tag, "pixels reg (R2)", vPix, 32'(it.pix));
        checkVal(it.tag, "lines reg (R3)", vLines, 32'(it.lines));
        checkVal(it.tag, "status reg R9", vStat, 32'(it.lock) << 8);
        checkVal(it.tag, "locked port", {31'b0, lockPort}, {31'b0, it.lock});
        checkVal("R9", "unused address", vNone, 32'd0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1;
    vsyncIn = 0; hsyncIn = 0; vblankIn = 0; hblankIn = 0; dataValid = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    pushExp("R10 reset", 0, 0, 0);
    idleCycles(10);

    // Initial acquisition at 16 x 6.
    driveFrame(16, 6, -1, 0, 0, "R4 first boundary", 0, 0, 0, "");
    driveFrame(16, 6, -1, 0, 0, "R3 first capture", 0, 16, 6, "");
    driveFrame(16, 6, -1, 0, 0, "R5 two frames", 0, 16, 6, "");
    driveFrame(16, 6, -1, 0, 1, "R5 lock on third", 1, 16, 6, "");
    // Corrupt the first line: drop mid-frame, no capture of 15.
    driveFrame(16, 6, 0, 15, 0, "R1 spurious DE ignored", 1, 16, 6, "R7 short line");
    driveFrame(16, 6, -1, 0, 0, "R4 nonuniform kept out", 0, 16, 6, "");
    driveFrame(16, 6, -1, 0, 0, "R6 restart one", 0, 16, 6, "");
    driveFrame(16, 6, -1, 0, 0, "R6 restart two", 0, 16, 6, "");
    // Line count change.
    driveFrame(16, 5, -1, 0, 0, "R5 relock", 1, 16, 6, "");
    driveFrame(16, 5, -1, 0, 0, "R6 line count change", 0, 16, 5, "");
    driveFrame(16, 5, -1, 0, 0, "R6 new count two", 0, 16, 5, "");
    driveFrame(20, 5, -1, 0, 0, "R5 lock new lines", 1, 16, 5, "");
    // Pixel count change, detected at first line end.
    driveFrame(20, 5, 0, 20, 0, "R2 new width captured", 0, 20, 5, "R7 width change");
    driveFrame(20, 5, -1, 0, 0, "R5 two at width 20", 0, 20, 5, "");
    driveFrame(20, 5, -1, 0, 0, "R5 lock width 20", 1, 20, 5, "");
    // Watchdog.
    idleCycles(100);
    pushExp("R8 not early", 1, 20, 5);
    idleCycles(300);
    pushExp("R8 expiry", 0, 20, 5);
    idleCycles(10);
    driveFrame(20, 5, -1, 0, 0, "R8 opens only", 0, 20, 5, "");
    driveFrame(20, 5, -1, 0, 0, "R8 count one", 0, 20, 5, "");
    driveFrame(20, 5, -1, 0, 0, "R8 count two", 0, 20, 5, "");
    driveFrame(20, 5, -1, 0, 0, "R5 lock after expiry", 1, 20, 5, "");
    step(1, 0, 1, 1, 0);
    pushExp("R5 closing edge", 1, 20, 5);
    step(1, 0, 1, 1, 0);
    idleCycles(12);
    // Reset while locked.
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    pushExp("R10 reset while locked", 0, 0, 0);
    while (expQ.size() != 0) @(negedge clk);
    idleCycles(10);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule